// File: doc/BRIEF.md
# Rotating Framebuffer Fetch Address Generator

This block turns the geometry of one plane of a display layer into a stream of byte addresses, one for each pixel, in the order a fetch engine must read them so that the picture comes out rotated by 0, 90, 180 or 270 degrees. A start pulse captures the whole configuration: base address, plane offset, source position, clipping offsets, visible width and height (already swapped by the caller for quarter turns), bytes per pixel, line pitch, plane index, chroma subsampling and rotation. A two-stage pipeline then works out the start offset and two signed strides. One increments after every pixel and the other after the last pixel of each line.

After the geometry is ready, a walker adds either the pixel step or the line step to a running address. It presents each address on a valid/ready interface, and the final pixel carries a last flag. Chroma planes (any plane index other than zero) divide their coordinates by power-of-two subsampling factors, so the same walker serves packed and planar buffers in all four orientations.

Top module: `rot_fetch_agen`

## Requirements
- R1: `start_i` is accepted only while idle. If it is sampled at edge k, `done_o` is high for exactly one cycle after edge k+2. From then until the next accepted start, `start_off_o`, `xstride_o` and `pstride_o` hold the computed values.
- R2: The subsampling inputs are shift counts, where value s divides by 2^s. They take effect only when `plane_idx_i` is non-zero. For plane 0 both shifts are treated as 0.
- R3: Rotation 0: start = ((clip_y+src_y)>>vs)*pitch + ((clip_x+src_x)>>hs)*bpp + plane offset. xstride = pitch - (w>>hs)*bpp. pstride = 0. There are w>>hs pixels per line and h>>vs lines.
- R4: Rotation 180: row = (clip_y+src_y+h-1)>>vs and column = (clip_x+src_x+w-1)>>hs. xstride = (((w-1)>>hs)-1)*bpp - pitch. pstride = -2*bpp. There are ((w-1)>>hs)+1 pixels per line and ((h-1)>>vs)+1 lines.
- R5: Rotation 90: row = (clip_y+src_y+w-1)>>vs and column = (clip_x+src_x)>>hs. xstride = ((w-1)>>vs)*pitch. pstride = -pitch-bpp. There are ((w-1)>>vs)+1 pixels per line and h>>hs lines.
- R6: Rotation 270: row = (clip_y+src_y)>>vs and column = (clip_x+src_x+h-1)>>hs. xstride = -((w-1)>>vs)*pitch - 2*bpp. pstride = pitch-bpp. There are ((w-1)>>vs)+1 pixels per line and ((h-1)>>hs)+1 lines.
- R7: `rot_i` encodes 0 as 0°, 1 as 90°, 2 as 180° and 3 as 270°. In every case the start offset is row*pitch + column*bpp + plane offset.
- R8: The first address is base + start offset. After each accepted pixel the address grows by bpp + pstride, or by bpp + xstride after the last pixel of a line. All arithmetic wraps modulo 2^32.
- R9: The stream starts in the cycle after `done_o` and stays valid until the final pixel of the final line is accepted. `last_o` is high only on that pixel, and `valid_o` is low in the following cycle.
- R10: While `valid_o` is high and `ready_i` is low, `addr_o` and `last_o` hold.
- R11: If bpp is zero, or the width, height, pixel count per line or line count is zero, `err_o` pulses for one cycle in place of `done_o` and no address is streamed.
- R12: A `start_i` that arrives while a computation or stream is in progress has no effect on the running stream and produces no `done_o`.
- R13: During reset `valid_o`, `done_o`, `err_o`, `addr_o` and the three computed outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture configuration and begin |
| rot_i | input | 2 | Rotation code |
| plane_idx_i | input | 2 | Plane index, 0 = luma or packed |
| hsub_sh_i | input | 2 | Horizontal subsampling shift |
| vsub_sh_i | input | 2 | Vertical subsampling shift |
| src_x_i | input | DIM_W | Source x position |
| src_y_i | input | DIM_W | Source y position |
| clip_x_i | input | DIM_W | Clipping x offset |
| clip_y_i | input | DIM_W | Clipping y offset |
| width_i | input | DIM_W | Visible source width |
| height_i | input | DIM_W | Visible source height |
| bpp_i | input | BPP_W | Bytes per pixel |
| pitch_i | input | PITCH_W | Line pitch in bytes |
| base_i | input | AW | Buffer base address |
| plane_off_i | input | AW | Per-plane buffer offset |
| done_o | output | 1 | Geometry ready pulse |
| err_o | output | 1 | Configuration error pulse |
| start_off_o | output | AW | Computed start offset |
| xstride_o | output | AW | Line stride, two's complement |
| pstride_o | output | AW | Pixel stride, two's complement |
| valid_o | output | 1 | Address valid |
| ready_i | input | 1 | Address accepted |
| addr_o | output | AW | Pixel byte address |
| last_o | output | 1 | Final pixel of the plane |

## Verification
The bench drives a start pulse on a falling edge and waits through the capture edge and both pipeline edges. It then samples `done_o`, `err_o`, the start offset and the strides on the falling edge after the third rising edge, where R1 places them. The first address is due one rising edge later. After that, each address is compared on a falling edge, and only when `valid_o` and the randomly driven `ready_i` are both high, so each comparison refers to the beat the next rising edge will accept. One falling edge after the final beat, the bench checks that `valid_o` has dropped.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  typedef enum logic [1:0] {
    ROT_0   = 2'd0,
    ROT_90  = 2'd1,
    ROT_180 = 2'd2,
    ROT_270 = 2'd3
  } rot_e;
endpackage

// File: rtl/rfa_geom.sv
module rfa_geom
  import rfa_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DIM_W   = 12,
  parameter int PITCH_W = 16,
  parameter int BPP_W   = 3,
  localparam int CW     = DIM_W + 1,
  localparam int RW     = DIM_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               calc_i,
  input  rot_e               rot_i,
  input  logic               chroma_i,
  input  logic [1:0]         hsh_i,
  input  logic [1:0]         vsh_i,
  input  logic [DIM_W-1:0]   x_i,
  input  logic [DIM_W-1:0]   y_i,
  input  logic [DIM_W-1:0]   cx_i,
  input  logic [DIM_W-1:0]   cy_i,
  input  logic [DIM_W-1:0]   w_i,
  input  logic [DIM_W-1:0]   h_i,
  input  logic [BPP_W-1:0]   bpp_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [AW-1:0]      poff_i,
  output logic               done_o,
  output logic               err_o,
  output logic [AW-1:0]      start_o,
  output logic [AW-1:0]      xstride_o,
  output logic [AW-1:0]      pstride_o,
  output logic [CW-1:0]      ppl_o,
  output logic [CW-1:0]      lines_o
);
  // stage 1: rows, columns, counts, stride multiplier
  logic [1:0]       hs, vs;
  logic [DIM_W-1:0] wm1, hm1;
  logic [RW-1:0]    xa, ya, row_d, col_d;
  logic [CW-1:0]    ppl_d, lines_d;
  logic [AW-1:0]    k_d;
  logic             bad_d;

  always_comb begin
    hs  = chroma_i ? hsh_i : 2'd0;
    vs  = chroma_i ? vsh_i : 2'd0;
    wm1 = w_i - DIM_W'(1);
    hm1 = h_i - DIM_W'(1);
    xa  = RW'(cx_i) + RW'(x_i);
    ya  = RW'(cy_i) + RW'(y_i);
    unique case (rot_i)
      ROT_180: begin
        row_d   = (ya + RW'(hm1)) >> vs;
        col_d   = (xa + RW'(wm1)) >> hs;
        k_d     = AW'(wm1 >> hs) - AW'(1);
        ppl_d   = CW'(wm1 >> hs) + CW'(1);
        lines_d = CW'(hm1 >> vs) + CW'(1);
      end
      ROT_90: begin
        row_d   = (ya + RW'(wm1)) >> vs;
        col_d   = xa >> hs;
        k_d     = AW'(wm1 >> vs);
        ppl_d   = CW'(wm1 >> vs) + CW'(1);
        lines_d = CW'(h_i >> hs);
      end
      ROT_270: begin
        row_d   = ya >> vs;
        col_d   = (xa + RW'(hm1)) >> hs;
        k_d     = AW'(wm1 >> vs);
        ppl_d   = CW'(wm1 >> vs) + CW'(1);
        lines_d = CW'(hm1 >> hs) + CW'(1);
      end
      default: begin
        row_d   = ya >> vs;
        col_d   = xa >> hs;
        k_d     = AW'(w_i >> hs);
        ppl_d   = CW'(w_i >> hs);
        lines_d = CW'(h_i >> vs);
      end
    endcase
    bad_d = (bpp_i == '0) || (w_i == '0) || (h_i == '0) ||
            (ppl_d == '0) || (lines_d == '0);
  end

  logic          s1_v, s1_bad;
  logic [RW-1:0] row_q, col_q;
  logic [AW-1:0] k_q;
  logic [CW-1:0] ppl_q, lines_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_bad  <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      k_q     <= '0;
      ppl_q   <= '0;
      lines_q <= '0;
    end else begin
      s1_v <= calc_i;
      if (calc_i) begin
        s1_bad  <= bad_d;
        row_q   <= row_d;
        col_q   <= col_d;
        k_q     <= k_d;
        ppl_q   <= ppl_d;
        lines_q <= lines_d;
      end
    end
  end

  // stage 2: products and strides
  logic [AW-1:0] bpp_w, pitch_w, st_d, xs_d, ps_d;
  always_comb begin
    bpp_w   = AW'(bpp_i);
    pitch_w = AW'(pitch_i);
    st_d    = AW'(row_q) * pitch_w + AW'(col_q) * bpp_w + poff_i;
    unique case (rot_i)
      ROT_180: begin
        xs_d = k_q * bpp_w - pitch_w;
        ps_d = '0 - (bpp_w << 1);
      end
      ROT_90: begin
        xs_d = k_q * pitch_w;
        ps_d = '0 - pitch_w - bpp_w;
      end
      ROT_270: begin
        xs_d = '0 - k_q * pitch_w - (bpp_w << 1);
        ps_d = pitch_w - bpp_w;
      end
      default: begin
        xs_d = pitch_w - k_q * bpp_w;
        ps_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      start_o   <= '0;
      xstride_o <= '0;
      pstride_o <= '0;
      ppl_o     <= '0;
      lines_o   <= '0;
    end else begin
      done_o <= s1_v && !s1_bad;
      err_o  <= s1_v && s1_bad;
      if (s1_v && !s1_bad) begin
        start_o   <= st_d;
        xstride_o <= xs_d;
        pstride_o <= ps_d;
        ppl_o     <= ppl_q;
        lines_o   <= lines_q;
      end
    end
  end
endmodule

// File: rtl/rfa_walker.sv
module rfa_walker #(
  parameter int AW    = 32,
  parameter int BPP_W = 3,
  parameter int CW    = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    start_i,
  input  logic [AW-1:0]    xstride_i,
  input  logic [AW-1:0]    pstride_i,
  input  logic [BPP_W-1:0] bpp_i,
  input  logic [CW-1:0]    ppl_i,
  input  logic [CW-1:0]    lines_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [AW-1:0]    addr_o,
  output logic             last_o,
  output logic             fin_o
);
  logic [CW-1:0] pix_q, line_q;
  logic          line_end, plane_end, fire;

  assign line_end  = (pix_q == ppl_i - CW'(1));
  assign plane_end = line_end && (line_q == lines_i - CW'(1));
  assign fire      = valid_o && ready_i;
  assign last_o    = valid_o && plane_end;
  assign fin_o     = fire && plane_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      pix_q   <= '0;
      line_q  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= base_i + start_i;
      pix_q   <= '0;
      line_q  <= '0;
    end else if (fire) begin
      if (plane_end) begin
        valid_o <= 1'b0;
      end else if (line_end) begin
        addr_o <= addr_o + AW'(bpp_i) + xstride_i;
        pix_q  <= '0;
        line_q <= line_q + CW'(1);
      end else begin
        addr_o <= addr_o + AW'(bpp_i) + pstride_i;
        pix_q  <= pix_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rot_fetch_agen.sv
module rot_fetch_agen
  import rfa_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DIM_W   = 12,
  parameter int PITCH_W = 16,
  parameter int BPP_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         rot_i,
  input  logic [1:0]         plane_idx_i,
  input  logic [1:0]         hsub_sh_i,
  input  logic [1:0]         vsub_sh_i,
  input  logic [DIM_W-1:0]   src_x_i,
  input  logic [DIM_W-1:0]   src_y_i,
  input  logic [DIM_W-1:0]   clip_x_i,
  input  logic [DIM_W-1:0]   clip_y_i,
  input  logic [DIM_W-1:0]   width_i,
  input  logic [DIM_W-1:0]   height_i,
  input  logic [BPP_W-1:0]   bpp_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [AW-1:0]      base_i,
  input  logic [AW-1:0]      plane_off_i,
  output logic               done_o,
  output logic               err_o,
  output logic [AW-1:0]      start_off_o,
  output logic [AW-1:0]      xstride_o,
  output logic [AW-1:0]      pstride_o,
  output logic               valid_o,
  input  logic               ready_i,
  output logic [AW-1:0]      addr_o,
  output logic               last_o
);
  localparam int CW = DIM_W + 1;

  logic               busy_q, calc_q, accept, fin;
  rot_e               rot_q;
  logic               chroma_q;
  logic [1:0]         hsh_q, vsh_q;
  logic [DIM_W-1:0]   x_q, y_q, cx_q, cy_q, w_q, h_q;
  logic [BPP_W-1:0]   bpp_q;
  logic [PITCH_W-1:0] pitch_q;
  logic [AW-1:0]      base_q, poff_q;
  logic [CW-1:0]      ppl, lines;

  assign accept = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      calc_q   <= 1'b0;
      rot_q    <= ROT_0;
      chroma_q <= 1'b0;
      hsh_q    <= '0;
      vsh_q    <= '0;
      x_q      <= '0;
      y_q      <= '0;
      cx_q     <= '0;
      cy_q     <= '0;
      w_q      <= '0;
      h_q      <= '0;
      bpp_q    <= '0;
      pitch_q  <= '0;
      base_q   <= '0;
      poff_q   <= '0;
    end else begin
      calc_q <= accept;
      if (accept) begin
        busy_q   <= 1'b1;
        rot_q    <= rot_e'(rot_i);
        chroma_q <= (plane_idx_i != 2'd0);
        hsh_q    <= hsub_sh_i;
        vsh_q    <= vsub_sh_i;
        x_q      <= src_x_i;
        y_q      <= src_y_i;
        cx_q     <= clip_x_i;
        cy_q     <= clip_y_i;
        w_q      <= width_i;
        h_q      <= height_i;
        bpp_q    <= bpp_i;
        pitch_q  <= pitch_i;
        base_q   <= base_i;
        poff_q   <= plane_off_i;
      end else if (err_o || fin) begin
        busy_q <= 1'b0;
      end
    end
  end

  rfa_geom #(
    .AW(AW), .DIM_W(DIM_W), .PITCH_W(PITCH_W), .BPP_W(BPP_W)
  ) u_geom (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .calc_i    (calc_q),
    .rot_i     (rot_q),
    .chroma_i  (chroma_q),
    .hsh_i     (hsh_q),
    .vsh_i     (vsh_q),
    .x_i       (x_q),
    .y_i       (y_q),
    .cx_i      (cx_q),
    .cy_i      (cy_q),
    .w_i       (w_q),
    .h_i       (h_q),
    .bpp_i     (bpp_q),
    .pitch_i   (pitch_q),
    .poff_i    (poff_q),
    .done_o    (done_o),
    .err_o     (err_o),
    .start_o   (start_off_o),
    .xstride_o (xstride_o),
    .pstride_o (pstride_o),
    .ppl_o     (ppl),
    .lines_o   (lines)
  );

  rfa_walker #(
    .AW(AW), .BPP_W(BPP_W), .CW(CW)
  ) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (done_o),
    .base_i    (base_q),
    .start_i   (start_off_o),
    .xstride_i (xstride_o),
    .pstride_i (pstride_o),
    .bpp_i     (bpp_q),
    .ppl_i     (ppl),
    .lines_i   (lines),
    .ready_i   (ready_i),
    .valid_o   (valid_o),
    .addr_o    (addr_o),
    .last_o    (last_o),
    .fin_o     (fin)
  );
endmodule

// File: rtl/rfa_checker.sv
module rfa_checker #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          err_o,
  input logic          valid_o,
  input logic          ready_i,
  input logic          last_o,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] xstride_o,
  input logic [AW-1:0] pstride_o
);
  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_strides_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> $stable(xstride_o) && $stable(pstride_o));

  assert_stream_follows_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> valid_o);

  assert_keep_streaming_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last_o |=> valid_o);

  assert_stream_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o |=> !valid_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(last_o));

  assert_done_err_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o}));

  assert_err_no_stream_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !valid_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R13: assert (!valid_o && !done_o && !err_o && addr_o == '0);
    end
  end
endmodule

bind rot_fetch_agen rfa_checker #(.AW(AW)) u_rfa_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_o    (done_o),
  .err_o     (err_o),
  .valid_o   (valid_o),
  .ready_i   (ready_i),
  .last_o    (last_o),
  .addr_o    (addr_o),
  .xstride_o (xstride_o),
  .pstride_o (pstride_o)
);

// File: tb/tb_rot_fetch_agen.sv
`timescale 1ns/1ps
module tb_rot_fetch_agen;
  localparam int AW = 32, DIM_W = 12, PITCH_W = 16, BPP_W = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] rot_i = '0, plane_idx_i = '0, hsub_sh_i = '0, vsub_sh_i = '0;
  logic [DIM_W-1:0] src_x_i = '0, src_y_i = '0, clip_x_i = '0, clip_y_i = '0;
  logic [DIM_W-1:0] width_i = '0, height_i = '0;
  logic [BPP_W-1:0] bpp_i = '0;
  logic [PITCH_W-1:0] pitch_i = '0;
  logic [AW-1:0] base_i = '0, plane_off_i = '0;
  logic done_o, err_o, valid_o, last_o;
  logic ready_i = 1'b0;
  logic [AW-1:0] start_off_o, xstride_o, pstride_o, addr_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  rot_fetch_agen #(.AW(AW), .DIM_W(DIM_W), .PITCH_W(PITCH_W), .BPP_W(BPP_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rot_i(rot_i),
    .plane_idx_i(plane_idx_i), .hsub_sh_i(hsub_sh_i), .vsub_sh_i(vsub_sh_i),
    .src_x_i(src_x_i), .src_y_i(src_y_i), .clip_x_i(clip_x_i), .clip_y_i(clip_y_i),
    .width_i(width_i), .height_i(height_i), .bpp_i(bpp_i), .pitch_i(pitch_i),
    .base_i(base_i), .plane_off_i(plane_off_i), .done_o(done_o), .err_o(err_o),
    .start_off_o(start_off_o), .xstride_o(xstride_o), .pstride_o(pstride_o),
    .valid_o(valid_o), .ready_i(ready_i), .addr_o(addr_o), .last_o(last_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string rtag(input int rot);
    case (rot)
      1: return "R5/R7";
      2: return "R4/R7";
      3: return "R6/R7";
      default: return "R3/R7";
    endcase
  endfunction

  function automatic void ref_model(
    input int rot, plane, hsh, vsh, x, y, cx, cy, w, h, bpp, pitch,
    input logic [31:0] poff,
    output logic [31:0] st, xs, ps, output int ppl, lines, output bit bad);
    int hs, vs, row, col;
    hs = (plane != 0) ? hsh : 0;
    vs = (plane != 0) ? vsh : 0;
    row = 0; col = 0; ppl = 0; lines = 0; xs = '0; ps = '0;
    if (w > 0 && h > 0) begin
      case (rot)
        0: begin
          row = (cy + y) >> vs; col = (cx + x) >> hs;
          xs = pitch - (w >> hs) * bpp; ps = 0;
          ppl = w >> hs; lines = h >> vs;
        end
        2: begin
          row = (cy + y + h - 1) >> vs; col = (cx + x + w - 1) >> hs;
          xs = (((w - 1) >> hs) - 1) * bpp - pitch; ps = -2 * bpp;
          ppl = ((w - 1) >> hs) + 1; lines = ((h - 1) >> vs) + 1;
        end
        1: begin
          row = (cy + y + w - 1) >> vs; col = (cx + x) >> hs;
          xs = ((w - 1) >> vs) * pitch; ps = -pitch - bpp;
          ppl = ((w - 1) >> vs) + 1; lines = h >> hs;
        end
        default: begin
          row = (cy + y) >> vs; col = (cx + x + h - 1) >> hs;
          xs = -(((w - 1) >> vs) * pitch) - 2 * bpp; ps = pitch - bpp;
          ppl = ((w - 1) >> vs) + 1; lines = ((h - 1) >> hs) + 1;
        end
      endcase
    end
    st = 32'(row * pitch + col * bpp) + poff;
    bad = (bpp == 0) || (w == 0) || (h == 0) || (ppl == 0) || (lines == 0);
  endfunction

  task automatic run(input int rot, plane, hsh, vsh, x, y, cx, cy, w, h, bpp, pitch,
                     input logic [31:0] base, poff, input bit inject);
    logic [31:0] st, xs, ps, ea;
    int ppl, lines, p, l, idx;
    bit bad;
    string tg;
    ref_model(rot, plane, hsh, vsh, x, y, cx, cy, w, h, bpp, pitch, poff, st, xs, ps, ppl, lines, bad);
    tg = (plane != 0) ? {rtag(rot), "+R2"} : rtag(rot);
    @(negedge clk_i);
    rot_i = 2'(rot); plane_idx_i = 2'(plane); hsub_sh_i = 2'(hsh); vsub_sh_i = 2'(vsh);
    src_x_i = DIM_W'(x); src_y_i = DIM_W'(y); clip_x_i = DIM_W'(cx); clip_y_i = DIM_W'(cy);
    width_i = DIM_W'(w); height_i = DIM_W'(h); bpp_i = BPP_W'(bpp); pitch_i = PITCH_W'(pitch);
    base_i = base; plane_off_i = poff; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i); start_i = 1'b0;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    if (bad) begin
      chk("R11 err", 32'(err_o), 1);
      chk("R11 no done", 32'(done_o), 0);
      @(negedge clk_i);
      chk("R11 no stream", 32'(valid_o), 0);
      return;
    end
    chk("R1 done", 32'(done_o), 1);
    chk({tg, " start"}, start_off_o, st);
    chk({tg, " xstride"}, xstride_o, xs);
    chk({tg, " pstride"}, pstride_o, ps);
    ea = base + st; p = 0; l = 0; idx = 0;
    while (idx < ppl * lines) begin
      @(negedge clk_i);
      ready_i = ($urandom % 4) != 0;
      if (inject && idx == 1) begin
        start_i = 1'b1; base_i = $urandom; rot_i = 2'($urandom);
      end else begin
        start_i = 1'b0;
      end
      if (done_o) chk("R12 no done while busy", 32'(done_o), 0);
      chk("R9 valid", 32'(valid_o), 1);
      if (valid_o && ready_i) begin
        chk(inject ? "R12 addr" : "R8/R10 addr", addr_o, ea);
        chk("R9 last", 32'(last_o), 32'((p == ppl - 1) && (l == lines - 1)));
        if (p == ppl - 1) begin
          ea = ea + 32'(bpp) + xs; p = 0; l++;
        end else begin
          ea = ea + 32'(bpp) + ps; p++;
        end
        idx++;
      end
    end
    @(negedge clk_i);
    start_i = 1'b0; ready_i = 1'b0;
    chk("R9 end", 32'(valid_o), 0);
    chk("R12 no late done", 32'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk_i);
    // R13 reset state
    chk("R13 valid", 32'(valid_o), 0);
    chk("R13 done", 32'(done_o), 0);
    chk("R13 err", 32'(err_o), 0);
    chk("R13 addr", addr_o, 0);
    chk("R13 start", start_off_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    // each rotation, packed plane
    for (int r = 0; r < 4; r++)
      run(r, 0, 0, 0, 3, 2, 1, 1, 4, 3, 2, 32, 32'h1000_0000, 32'h40, 1'b0);
    // chroma planes with subsampling (R2) and plane 0 ignoring shifts
    for (int r = 0; r < 4; r++)
      run(r, 1, 1, 1, 4, 6, 2, 0, 6, 4, 1, 24, 32'h2000_0000, 32'h100, 1'b0);
    run(0, 0, 2, 2, 1, 1, 0, 0, 3, 3, 2, 16, 32'h3000, 0, 1'b0);
    run(2, 2, 1, 0, 5, 3, 1, 2, 5, 3, 2, 40, 32'h3000, 32'h80, 1'b0);
    // errors (R11)
    run(0, 0, 0, 0, 0, 0, 0, 0, 4, 4, 0, 32, 0, 0, 1'b0);
    run(0, 1, 2, 0, 0, 0, 0, 0, 2, 4, 1, 32, 0, 0, 1'b0);
    run(1, 0, 0, 0, 0, 0, 0, 0, 4, 0, 2, 32, 0, 0, 1'b0);
    // address wrap (R8)
    run(2, 0, 0, 0, 0, 0, 0, 0, 3, 2, 4, 16, 32'hFFFF_FFF0, 32'h0, 1'b0);
    run(0, 0, 0, 0, 2, 0, 0, 0, 3, 2, 4, 16, 32'hFFFF_FFF0, 32'h0, 1'b0);
    // start while busy (R12)
    run(3, 0, 0, 0, 2, 2, 0, 0, 3, 3, 3, 48, 32'h5000, 32'h10, 1'b1);
    // constrained random
    for (int i = 0; i < 40; i++)
      run(int'($urandom % 4), int'($urandom % 3), int'($urandom % 3), int'($urandom % 3),
          int'($urandom % 20), int'($urandom % 20), int'($urandom % 4), int'($urandom % 4),
          int'(1 + $urandom % 8), int'(1 + $urandom % 8), int'($urandom % 5),
          int'(16 + $urandom % 64), $urandom, 32'($urandom % 256), ($urandom % 4) == 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule